// File: doc/BRIEF.md
# Clause-45 MDIO Management Master

This block is a management-bus master for a network chip. A command register and a data register accept one clause-45 register access at a time. A write to the command register with its launch bit set starts the access. The engine then produces the MDC clock and drives the serial MDIO line until the access completes. Every access takes two frames. The first frame carries the 16-bit register address. The second frame writes the contents of the data register, or reads 16 bits from the addressed port and device.

The busy bit in the command register stays set while the two frames run and clears by itself when they finish. Software sets the data register before it launches a write. After a read it takes the result from the upper half of the same register. The engine watches the MDC pad through a feedback input, and it advances a clock phase only once the pad shows the level it drives. If a phase does not finish within a bounded number of system clocks, the engine abandons the access, releases the bus and raises an error bit.

Top module: `mdio45_engine`

## Requirements
- R1: A command write with bit 30 set, an operation field [27:26] of 01 (write) or 11 (read), and the engine idle starts an access. In the cycle after the write, bit 30 of the command readback is 1 and bit 31 (error) is 0. The register address is held in [15:0], the device type in [20:16] and the port address in [25:21].
- R2: Each access sends an address frame with opcode 00 and the register address in the data field. It then sends a second frame with the command's opcode to the same port and device.
- R3: Each frame is 64 MDC periods long, sent MSB first: 32 ones, start code 00, 2-bit opcode, 5-bit port, 5-bit device, turnaround 10, then 16 data bits.
- R4: Bit 30 clears by itself when the second frame ends. While it is clear, MDC is low and MDIO is not driven.
- R5: A write frame carries data register bits [15:0]. Writes to the data register while an access runs are ignored.
- R6: In a read frame the master releases MDIO for both turnaround bits and for the 16 data bits. The captured bits land in data register [31:16], and [15:0] keep their value.
- R7: MDIO changes only while MDC is low and is sampled when MDC rises. Each MDC half period lasts HALF_DIV system clocks.
- R8: A command write is ignored, and leaves the readback unchanged, in any of these cases: the engine is busy, bit 30 is clear, or the operation field is 00 or 10.
- R9: If a phase lasts TIMEOUT_CYC clocks (for example because the MDC feedback does not follow), the access stops in that cycle. Bit 30 clears, bit 31 sets, and the next launch clears bit 31.
- R10: After reset both registers read zero, MDC is low and MDIO is not driven.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_wr | input | 1 | Write strobe for the command register |
| cmd_wdata | input | 32 | Command word: launch bit 30, op [27:26], port [25:21], device [20:16], register [15:0] |
| data_wr | input | 1 | Write strobe for the data register |
| data_wdata | input | 32 | Data register write value; write data in [15:0] |
| cmd_rdata | output | 32 | Command readback: error bit 31, busy bit 30, stored fields in [27:0] |
| data_rdata | output | 32 | Data register; read result in [31:16] |
| mdc | output | 1 | Management clock |
| mdc_fb | input | 1 | Level observed on the MDC pad |
| mdio_o | output | 1 | MDIO output value |
| mdio_oe | output | 1 | MDIO output enable |
| mdio_i | input | 1 | MDIO pad input |

## Verification
The bound checker watches four things on every cycle. When the engine is idle, MDC is low and MDIO is released. MDIO never changes while MDC is high during an access. Neither the stored command nor the write half of the data register moves in response to writes made while busy. Read data changes only on a register write or when an access completes. It also bounds how long busy can stay set. Only the bench scenarios can show the actual bit content of each frame, the release window of a read, the half-period length, the exact cycle of a timeout, and the rejection of invalid operation codes.

// File: rtl/mdio45_pkg.sv
package mdio45_pkg;

  // Protocol constants of one clause-45 management frame
  localparam int FRAME_BITS = 64;
  localparam int TA_POS     = 46;   // first turnaround bit index
  localparam int DATA_POS   = 48;   // first data bit index

  typedef enum logic [1:0] {
    OP_ADDR  = 2'b00,
    OP_WRITE = 2'b01,
    OP_RSVD  = 2'b10,
    OP_READ  = 2'b11
  } mdio_op_e;

  // Stored command fields, laid out as seen at cmd_rdata[27:0]
  typedef struct packed {
    logic [1:0]  op;
    logic [4:0]  port;
    logic [4:0]  dev;
    logic [15:0] regad;
  } mdio_cmd_t;

  typedef enum logic [1:0] {
    S_IDLE = 2'd0,
    S_ADDR = 2'd1,
    S_XFER = 2'd2
  } seq_state_e;

  function automatic logic [FRAME_BITS-1:0] mk_frame(
    input logic [1:0]  op,
    input logic [4:0]  port,
    input logic [4:0]  dev,
    input logic [15:0] payload
  );
    return {32'hFFFF_FFFF, 2'b00, op, port, dev, 2'b10, payload};
  endfunction

endpackage

// File: rtl/mdio45_mdc_gen.sv
module mdio45_mdc_gen #(
  parameter int HALF_DIV = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  input  logic restart,
  input  logic abort,
  input  logic mdc_fb,
  output logic mdc,
  output logic rise_tick,
  output logic fall_tick
);
  localparam int CW = (HALF_DIV > 2) ? $clog2(HALF_DIV) : 1;

  logic [CW-1:0] cnt;
  logic          mdc_q;
  logic          at_end;
  logic          settled;
  logic          tick;

  assign at_end    = (cnt == CW'(HALF_DIV - 1));
  assign settled   = (mdc_fb == mdc_q);
  assign tick      = run && at_end && settled;
  assign rise_tick = tick && !mdc_q;
  assign fall_tick = tick && mdc_q;
  assign mdc       = mdc_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt   <= '0;
      mdc_q <= 1'b0;
    end else if (abort || restart || !run) begin
      cnt   <= '0;
      mdc_q <= 1'b0;
    end else if (tick) begin
      cnt   <= '0;
      mdc_q <= !mdc_q;
    end else if (!at_end) begin
      cnt <= cnt + CW'(1);
    end
  end

endmodule

// File: rtl/mdio45_frame_shift.sv
module mdio45_frame_shift
  import mdio45_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  start,
  input  logic                  abort,
  input  logic                  rise_tick,
  input  logic                  fall_tick,
  input  logic [FRAME_BITS-1:0] frame_in,
  input  logic                  is_read,
  input  logic                  mdio_i,
  output logic                  active,
  output logic                  mdio_o,
  output logic                  mdio_oe,
  output logic                  frame_end,
  output logic [15:0]           rx_data
);
  localparam int IW = $clog2(FRAME_BITS);

  logic [FRAME_BITS-1:0] sh;
  logic [IW-1:0]         idx;
  logic [IW-1:0]         idx_nx;
  logic                  rd_q;

  assign idx_nx    = idx + IW'(1);
  assign frame_end = active && fall_tick && (idx == IW'(FRAME_BITS - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      sh      <= '0;
      idx     <= '0;
      active  <= 1'b0;
      rd_q    <= 1'b0;
      mdio_o  <= 1'b1;
      mdio_oe <= 1'b0;
      rx_data <= '0;
    end else if (start) begin
      sh      <= frame_in;
      idx     <= '0;
      active  <= 1'b1;
      rd_q    <= is_read;
      mdio_o  <= frame_in[FRAME_BITS-1];
      mdio_oe <= 1'b1;
    end else if (abort) begin
      active  <= 1'b0;
      mdio_o  <= 1'b1;
      mdio_oe <= 1'b0;
    end else if (active) begin
      if (rise_tick && rd_q && (idx >= IW'(DATA_POS)))
        rx_data <= {rx_data[14:0], mdio_i};
      if (frame_end) begin
        active  <= 1'b0;
        mdio_o  <= 1'b1;
        mdio_oe <= 1'b0;
      end else if (fall_tick) begin
        idx     <= idx_nx;
        sh      <= {sh[FRAME_BITS-2:0], 1'b1};
        mdio_o  <= sh[FRAME_BITS-2];
        mdio_oe <= !(rd_q && (idx_nx >= IW'(TA_POS)));
      end
    end
  end

endmodule

// File: rtl/mdio45_seq.sv
module mdio45_seq
  import mdio45_pkg::*;
#(
  parameter int TIMEOUT_CYC = 2048
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  cmd_wr,
  input  logic [31:0]           cmd_wdata,
  input  logic                  data_wr,
  input  logic [31:0]           data_wdata,
  input  logic                  frame_end,
  input  logic [15:0]           rx_data,
  output logic [31:0]           cmd_rdata,
  output logic [31:0]           data_rdata,
  output logic                  start,
  output logic                  abort,
  output logic [FRAME_BITS-1:0] frame,
  output logic                  is_read
);
  localparam int TW = $clog2(TIMEOUT_CYC + 1);

  seq_state_e state;
  mdio_cmd_t  cmd_q;
  mdio_cmd_t  cmd_new;
  logic       err_q;
  logic [31:0] data_q;
  logic [TW-1:0] tcnt;
  logic       op_ok;
  logic       launch;
  logic       busy;

  assign cmd_new = mdio_cmd_t'(cmd_wdata[27:0]);
  assign op_ok   = (cmd_new.op == OP_WRITE) || (cmd_new.op == OP_READ);
  assign busy    = (state != S_IDLE);
  assign launch  = !busy && cmd_wr && cmd_wdata[30] && op_ok;
  assign abort   = busy && (tcnt == TW'(TIMEOUT_CYC - 1));
  assign start   = launch || ((state == S_ADDR) && frame_end && !abort);
  assign is_read = !launch && (cmd_q.op == OP_READ);

  always_comb begin
    if (launch)
      frame = mk_frame(OP_ADDR, cmd_new.port, cmd_new.dev, cmd_new.regad);
    else
      frame = mk_frame(cmd_q.op, cmd_q.port, cmd_q.dev,
                       (cmd_q.op == OP_READ) ? 16'hFFFF : data_q[15:0]);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= S_IDLE;
      cmd_q  <= '0;
      err_q  <= 1'b0;
      data_q <= '0;
      tcnt   <= '0;
    end else if (abort) begin
      state <= S_IDLE;
      err_q <= 1'b1;
      tcnt  <= '0;
    end else begin
      unique case (state)
        S_IDLE: begin
          if (launch) begin
            cmd_q <= cmd_new;
            err_q <= 1'b0;
            tcnt  <= '0;
            state <= S_ADDR;
          end else if (data_wr) begin
            data_q <= data_wdata;
          end
        end
        S_ADDR: begin
          tcnt <= tcnt + TW'(1);
          if (frame_end) begin
            tcnt  <= '0;
            state <= S_XFER;
          end
        end
        S_XFER: begin
          tcnt <= tcnt + TW'(1);
          if (frame_end) begin
            tcnt  <= '0;
            state <= S_IDLE;
            if (cmd_q.op == OP_READ)
              data_q[31:16] <= rx_data;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assign cmd_rdata  = {err_q, busy, 2'b00, cmd_q};
  assign data_rdata = data_q;

endmodule

// File: rtl/mdio45_engine.sv
module mdio45_engine
  import mdio45_pkg::*;
#(
  parameter int HALF_DIV    = 4,
  parameter int TIMEOUT_CYC = 2048
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        cmd_wr,
  input  logic [31:0] cmd_wdata,
  input  logic        data_wr,
  input  logic [31:0] data_wdata,
  output logic [31:0] cmd_rdata,
  output logic [31:0] data_rdata,
  output logic        mdc,
  input  logic        mdc_fb,
  output logic        mdio_o,
  output logic        mdio_oe,
  input  logic        mdio_i
);
  logic                  start;
  logic                  abort;
  logic                  is_read;
  logic [FRAME_BITS-1:0] frame;
  logic                  active;
  logic                  frame_end;
  logic [15:0]           rx_data;
  logic                  rise_tick;
  logic                  fall_tick;

  mdio45_seq #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_seq (
    .clk        (clk),
    .rst        (rst),
    .cmd_wr     (cmd_wr),
    .cmd_wdata  (cmd_wdata),
    .data_wr    (data_wr),
    .data_wdata (data_wdata),
    .frame_end  (frame_end),
    .rx_data    (rx_data),
    .cmd_rdata  (cmd_rdata),
    .data_rdata (data_rdata),
    .start      (start),
    .abort      (abort),
    .frame      (frame),
    .is_read    (is_read)
  );

  mdio45_mdc_gen #(.HALF_DIV(HALF_DIV)) u_mdc (
    .clk       (clk),
    .rst       (rst),
    .run       (active),
    .restart   (start),
    .abort     (abort),
    .mdc_fb    (mdc_fb),
    .mdc       (mdc),
    .rise_tick (rise_tick),
    .fall_tick (fall_tick)
  );

  mdio45_frame_shift u_shift (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .abort     (abort),
    .rise_tick (rise_tick),
    .fall_tick (fall_tick),
    .frame_in  (frame),
    .is_read   (is_read),
    .mdio_i    (mdio_i),
    .active    (active),
    .mdio_o    (mdio_o),
    .mdio_oe   (mdio_oe),
    .frame_end (frame_end),
    .rx_data   (rx_data)
  );

endmodule

// File: rtl/mdio45_engine_chk.sv
module mdio45_engine_chk #(
  parameter int TIMEOUT_CYC = 2048
) (
  input logic        clk,
  input logic        rst,
  input logic        cmd_wr,
  input logic        data_wr,
  input logic [31:0] cmd_rdata,
  input logic [31:0] data_rdata,
  input logic        mdc,
  input logic        mdio_o,
  input logic        mdio_oe
);
  localparam int unsigned RUN_MAX = 2 * TIMEOUT_CYC;

  logic busy;
  int unsigned busy_run;

  assign busy = cmd_rdata[30];

  always_ff @(posedge clk) begin
    if (rst)
      busy_run <= 0;
    else if (!busy)
      busy_run <= 0;
    else if (busy_run <= RUN_MAX)
      busy_run <= busy_run + 1;
  end

  // R4: an idle engine keeps MDC low and MDIO released
  a_r4_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (!mdc && !mdio_oe));

  // R7: the driven MDIO value moves only while MDC is low
  a_r7_drive_on_low: assert property (@(posedge clk) disable iff (rst)
    (busy && !$stable(mdio_o)) |-> !mdc);

  // R8: command writes during an access leave the stored fields alone
  a_r8_cmd_locked: assert property (@(posedge clk) disable iff (rst)
    (busy && cmd_wr) |=> $stable(cmd_rdata[27:0]));

  // R5: data writes during an access do not reach the write half
  a_r5_data_locked: assert property (@(posedge clk) disable iff (rst)
    (busy && data_wr) |=> $stable(data_rdata[15:0]));

  // R6: the data register moves only on a write or at access completion
  a_r6_data_source: assert property (@(posedge clk) disable iff (rst)
    !$stable(data_rdata) |-> ($past(data_wr) || $fell(busy)));

  // R9: two phase budgets bound every access
  a_r9_bounded_busy: assert property (@(posedge clk) disable iff (rst)
    busy_run <= RUN_MAX);

endmodule

bind mdio45_engine mdio45_engine_chk #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .cmd_wr     (cmd_wr),
  .data_wr    (data_wr),
  .cmd_rdata  (cmd_rdata),
  .data_rdata (data_rdata),
  .mdc        (mdc),
  .mdio_o     (mdio_o),
  .mdio_oe    (mdio_oe)
);

// File: tb/mdio45_engine_bench.sv
module mdio45_engine_bench;
  localparam int CLK_PERIOD = 10;
  localparam int HALF_DIV   = 2;
  localparam int TIMEOUT_CYC = 400;
  localparam int NVEC = 4;
  localparam logic [63:0] OE_READ = 64'hFFFF_FFFF_FFFC_0000;

  // {op[59:58], port[57:53], dev[52:48], reg[47:32], wdata[31:16], rpat[15:0]}
  localparam logic [59:0] VEC [NVEC] = '{
    {2'b01, 5'h03, 5'h01, 16'h0000, 16'hA55A, 16'h0000},
    {2'b11, 5'h1F, 5'h07, 16'hFFFF, 16'h1234, 16'hC3E1},
    {2'b11, 5'h00, 5'h1E, 16'h8001, 16'h0000, 16'h0001},
    {2'b01, 5'h15, 5'h04, 16'h7FFE, 16'hFFFF, 16'h0000}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cmd_wr = 1'b0;
  logic [31:0] cmd_wdata = '0;
  logic data_wr = 1'b0;
  logic [31:0] data_wdata = '0;
  logic [31:0] cmd_rdata;
  logic [31:0] data_rdata;
  logic mdc, mdc_fb, mdio_o, mdio_oe, mdio_i;
  logic stuck = 1'b0;
  logic [15:0] rd_pat = '0;
  logic slave_bit;

  int checks = 0;
  int fails  = 0;
  int rcnt   = 0;
  int nfr    = 0;
  logic [63:0] fr_sh = '0;
  logic [63:0] oe_sh = '0;
  logic [63:0] fr_cap [4];
  logic [63:0] oe_cap [4];
  time rise_prev = 0;
  time rise_last = 0;

  always #(CLK_PERIOD/2) clk = !clk;

  assign mdc_fb = stuck ? 1'b0 : mdc;

  always_comb begin
    if ((rcnt % 64) == 47)      slave_bit = 1'b0;
    else if ((rcnt % 64) >= 48) slave_bit = rd_pat[63 - (rcnt % 64)];
    else                        slave_bit = 1'b1;
  end
  assign mdio_i = mdio_oe ? mdio_o : slave_bit;

  mdio45_engine #(.HALF_DIV(HALF_DIV), .TIMEOUT_CYC(TIMEOUT_CYC)) u_mdio45_engine (
    .clk(clk), .rst(rst), .cmd_wr(cmd_wr), .cmd_wdata(cmd_wdata),
    .data_wr(data_wr), .data_wdata(data_wdata), .cmd_rdata(cmd_rdata),
    .data_rdata(data_rdata), .mdc(mdc), .mdc_fb(mdc_fb), .mdio_o(mdio_o),
    .mdio_oe(mdio_oe), .mdio_i(mdio_i)
  );

  // Bus observer: one bit per MDC rise, grouped into 64-bit frames
  always @(posedge mdc) begin
    fr_sh = {fr_sh[62:0], mdio_i};
    oe_sh = {oe_sh[62:0], mdio_oe};
    rise_prev = rise_last;
    rise_last = $time;
    if ((rcnt % 64) == 63 && nfr < 4) begin
      fr_cap[nfr] = fr_sh;
      oe_cap[nfr] = oe_sh;
      nfr = nfr + 1;
    end
    rcnt = rcnt + 1;
  end

  function automatic logic [63:0] exp_frame(input logic [1:0] op, input logic [4:0] port,
                                            input logic [4:0] dev, input logic [15:0] d);
    return {32'hFFFF_FFFF, 2'b00, op, port, dev, 2'b10, d};
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic write_cmd(input logic [31:0] w);
    @(negedge clk); cmd_wr = 1'b1; cmd_wdata = w;
    @(negedge clk); cmd_wr = 1'b0;
  endtask

  task automatic write_data(input logic [31:0] w);
    @(negedge clk); data_wr = 1'b1; data_wdata = w;
    @(negedge clk); data_wr = 1'b0;
  endtask

  task automatic wait_idle(output int n);
    n = 0;
    while (cmd_rdata[30] && n < 5000) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic clear_obs();
    rcnt = 0; nfr = 0; fr_sh = '0; oe_sh = '0;
  endtask

  function automatic logic [31:0] mk_cmd(input logic [1:0] op, input logic [4:0] port,
                                         input logic [4:0] dev, input logic [15:0] ra);
    return {1'b0, 1'b1, 2'b00, op, port, dev, ra};
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int n;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R10: reset state
    chk("R10 cmd", 64'(cmd_rdata), 64'h0);
    chk("R10 data", 64'(data_rdata), 64'h0);
    chk("R10 pins", {62'h0, mdc, mdio_oe}, 64'h0);

    // Table walk: R1, R2, R3, R4, R5, R6
    for (int v = 0; v < NVEC; v++) begin
      logic [1:0] op; logic [4:0] pt, dv; logic [15:0] ra, wd, rp;
      {op, pt, dv, ra, wd, rp} = VEC[v];
      rd_pat = rp;
      write_data({16'h0000, wd});
      clear_obs();
      write_cmd(mk_cmd(op, pt, dv, ra));
      chk("R1 busy after launch", 64'(cmd_rdata[31:30]), 64'h1);
      wait_idle(n);
      @(negedge clk);
      chk("R4 busy cleared", 64'(cmd_rdata), 64'({2'b00, 2'b00, op, pt, dv, ra}));
      chk("R4 idle pins", {62'h0, mdc, mdio_oe}, 64'h0);
      chk("R2 frame count", 64'(nfr), 64'd2);
      chk("R2 R3 address frame", fr_cap[0], exp_frame(2'b00, pt, dv, ra));
      chk("R3 address frame driven", oe_cap[0], '1);
      if (op == 2'b11) begin
        chk("R6 read frame", fr_cap[1], exp_frame(2'b11, pt, dv, rp));
        chk("R6 read release window", oe_cap[1], OE_READ);
        chk("R6 read data placement", 64'(data_rdata), 64'({rp, wd}));
      end else begin
        chk("R5 write frame", fr_cap[1], exp_frame(2'b01, pt, dv, wd));
        chk("R5 write frame driven", oe_cap[1], '1);
        chk("R5 data kept", 64'(data_rdata), 64'({16'h0000, wd}));
      end
      if (v == 0)
        chk("R7 MDC period", 64'(rise_last - rise_prev), 64'(2 * HALF_DIV * CLK_PERIOD));
    end

    // R8: invalid opcodes and clear launch bit are ignored
    clear_obs();
    write_cmd({1'b0, 1'b1, 2'b00, 2'b10, 5'h01, 5'h02, 16'h0BAD});
    chk("R8 op 10 ignored", 64'(cmd_rdata), 64'({4'b0000, 2'b01, 5'h15, 5'h04, 16'h7FFE}));
    write_cmd({1'b0, 1'b1, 2'b00, 2'b00, 5'h01, 5'h02, 16'h0BAD});
    chk("R8 op 00 ignored", 64'(cmd_rdata[30]), 64'h0);
    write_cmd({1'b0, 1'b0, 2'b00, 2'b11, 5'h01, 5'h02, 16'h0BAD});
    chk("R8 no launch bit ignored", 64'(cmd_rdata), 64'({4'b0000, 2'b01, 5'h15, 5'h04, 16'h7FFE}));
    repeat (40) @(negedge clk);
    chk("R8 no frames sent", 64'(rcnt), 64'h0);

    // R8 and R5: writes during a running access
    clear_obs();
    write_data(32'h0000_5A5A);
    write_cmd(mk_cmd(2'b01, 5'h0A, 5'h03, 16'h1357));
    repeat (20) @(negedge clk);
    write_cmd(mk_cmd(2'b11, 5'h11, 5'h11, 16'hEEEE));
    write_data(32'h0000_9999);
    wait_idle(n);
    @(negedge clk);
    chk("R8 busy write ignored", 64'(cmd_rdata), 64'({4'b0000, 2'b01, 5'h0A, 5'h03, 16'h1357}));
    chk("R8 frames from first command", fr_cap[1], exp_frame(2'b01, 5'h0A, 5'h03, 16'h5A5A));
    chk("R5 busy data write ignored", 64'(data_rdata), 64'h5A5A);

    // R9: stalled MDC feedback triggers the phase timeout
    clear_obs();
    stuck = 1'b1;
    write_cmd(mk_cmd(2'b01, 5'h02, 5'h05, 16'h0042));
    wait_idle(n);
    chk("R9 timeout cycle", 64'(n), 64'(TIMEOUT_CYC));
    chk("R9 error flag", 64'(cmd_rdata), 64'({4'b1000, 2'b01, 5'h02, 5'h05, 16'h0042}));
    @(negedge clk);
    chk("R9 bus released", {62'h0, mdc, mdio_oe}, 64'h0);
    stuck = 1'b0;
    clear_obs();
    rd_pat = 16'hBEEF;
    write_cmd(mk_cmd(2'b11, 5'h04, 5'h01, 16'h0002));
    chk("R9 error cleared on launch", 64'(cmd_rdata[31:30]), 64'h1);
    wait_idle(n);
    @(negedge clk);
    chk("R9 recovery read", 64'(data_rdata), 64'h BEEF_5A5A);

    // R10: reset mid-run returns to the reset state
    write_cmd(mk_cmd(2'b01, 5'h01, 5'h01, 16'h0001));
    repeat (30) @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R10 reset during access", {cmd_rdata, data_rdata}, 64'h0);
    chk("R10 pins after reset", {62'h0, mdc, mdio_oe}, 64'h0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule